// File: doc/BRIEF.md
# Audio Channel Interrupt Status Aggregator

This block holds one pending-interrupt flag for each of three audio streams: a capture stream (ADC) and two playback streams (DAC1 and DAC2). Each stream's transfer engine sends a one-cycle completion pulse when its sample counter runs out. The block latches that pulse into the stream's pending flag, but only while the stream's interrupt enable is on. The three flags are ORed into a summary bit and into a level interrupt output. A host reads the result as one 32-bit status word.

The enables live in the serial-control register, which is written elsewhere. The block watches every write to that register and keeps its own copy of the three enable bits, honouring byte strobes. When a write turns an enable from 1 to 0, the matching pending flag is cleared at the same clock edge. This is the only way a flag is cleared. The status word has no write path. The UART and codec busy bits are not produced here and read as zero.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted, and after it is released, `stat_word` reads 0x00000060 and `irq` is 0. Reset also clears all three shadow enables, so completion pulses that follow reset set nothing until an enable is written.
- R2: Field positions are fixed. `stat_word` bit 0 is ADC pending, bit 1 is DAC2 pending and bit 2 is DAC1 pending. `done_pulse[0]`, `done_pulse[1]` and `done_pulse[2]` are the ADC, DAC2 and DAC1 completions. In serial-control data, bit 8 enables DAC1, bit 9 enables DAC2 and bit 10 enables ADC.
- R3: A completion pulse sets its pending bit only if that stream's enable, as held before the edge, is 1. The result is visible after the first rising clock edge, not before it.
- R4: A pending bit stays set through later pulses and through writes that leave its enable at 1.
- R5: A serial-control write that takes an enable from 1 to 0 clears the matching pending bit at that same edge.
- R6: When a disabling write and a completion pulse for the same stream arrive in the same cycle, the bit ends up clear.
- R7: A write that leaves an enable unchanged clears nothing. This covers writing 0 to an enable that is already 0, and writing 1 to an enable that is already 1.
- R8: `stat_word` bit 31 and `irq` both equal the OR of bits 2:0. Bits 6:5 read as 3. Every other bit reads 0.
- R9: Serial-control bytes are written only where `sctl_wstrb` is 1. The enables sit in byte lane 1, so a write with `sctl_wstrb[1]`=0, or with `sctl_wr`=0, leaves all enables and pending bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | 3 | Per-stream completion pulses: [0] ADC, [1] DAC2, [2] DAC1 |
| sctl_wr | input | 1 | Write strobe for the serial-control register |
| sctl_wdata | input | 32 | Serial-control write data |
| sctl_wstrb | input | 4 | Byte-lane enables for the serial-control write |
| stat_word | output | 32 | Status word for host reads |
| irq | output | 1 | Level interrupt, OR of the pending bits |

## Verification
Every result takes exactly one clock edge. The pending flags and the shadow enables are the only state, and both `stat_word` and `irq` come combinationally from the flags. A pulse or write applied in one cycle therefore shows up only after the next rising edge. The bench drives each vector on a falling edge. It then checks that the outputs still hold the previous value just after driving, and checks the new expected value one time unit after the following rising edge. The reset cases are sampled right after `rst_n` changes, because reset is asynchronous and acts without any edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Stream identifiers, numbered by their position in the status word.
  typedef enum logic [1:0] {
    STRM_ADC  = 2'd0,
    STRM_DAC2 = 2'd1,
    STRM_DAC1 = 2'd2
  } strm_id_e;

  // The enable bits in serial control run in the reverse order of the
  // pending bits: status bit i maps to enable bit en_lsb + (n_ch-1-i).
  function automatic int unsigned en_bit_pos(int unsigned st_idx,
                                             int unsigned n_ch,
                                             int unsigned en_lsb);
    return en_lsb + (n_ch - 1 - st_idx);
  endfunction

  // Byte lane that carries a given bit of the write data.
  function automatic int unsigned lane_of(int unsigned bit_pos);
    return bit_pos / 8;
  endfunction

  // Next value of one pending flag. A clear beats a set.
  function automatic logic pend_next(logic cur, logic hit, logic en, logic clr);
    return clr ? 1'b0 : (cur | (hit & en));
  endfunction

endpackage

// File: rtl/irq_en_shadow.sv
module irq_en_shadow
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned EN_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic [N_CH-1:0]     en_q,     // status-ordered enables
  output logic [N_CH-1:0]     en_fall   // enable going 1 -> 0 at this edge
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [N_CH-1:0] en_d;
  logic [N_CH-1:0] lane_hit;

  for (genvar i = 0; i < N_CH; i++) begin : g_en
    localparam int unsigned POS  = en_bit_pos(i, N_CH, EN_LSB);
    localparam int unsigned LANE = lane_of(POS);

    assign lane_hit[i] = wr & wstrb[LANE];
    assign en_d[i]     = lane_hit[i] ? wdata[POS] : en_q[i];
    assign en_fall[i]  = en_q[i] & ~en_d[i];

    // R9: without a write to this lane the enable holds
    p_lane_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_hit[i] |=> $stable(en_q[i]));

    // R5: a fall is only flagged for an enable that was on
    p_fall_from_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall[i] |=> !en_q[i] && $past(en_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  initial begin
    if (LANES * 8 != DATA_W) $error("DATA_W must be a multiple of 8");
    if (en_bit_pos(0, N_CH, EN_LSB) >= DATA_W) $error("enable field out of range");
  end

endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic en,
  input  logic clr,
  output logic pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next(pend, hit, en, clr);
  end

  // R3: an enabled completion with no clear sets the flag
  p_set_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en && !clr |=> pend);

  // R3: without an enabled hit a clear flag stays clear
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && !(hit && en) |=> !pend);

  // R4: a set flag holds unless cleared
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend);

  // R6: a clear wins even against a simultaneous hit
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);

endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack #(
  parameter int unsigned      DATA_W  = 32,
  parameter int unsigned      N_CH    = 3,
  parameter int unsigned      SUM_BIT = 31,
  parameter int unsigned      VC_LSB  = 5,
  parameter int unsigned      VC_W    = 2,
  parameter logic [VC_W-1:0]  VC_VAL  = '1
) (
  input  logic [N_CH-1:0]   pend,
  output logic [DATA_W-1:0] word,
  output logic              any
);

  assign any = |pend;

  always_comb begin
    word                 = '0;
    word[N_CH-1:0]       = pend;
    word[VC_LSB +: VC_W] = VC_VAL;
    word[SUM_BIT]        = any;
  end

  initial begin
    if (VC_LSB < N_CH) $error("voice field overlaps pending bits");
    if (SUM_BIT < VC_LSB + VC_W) $error("summary bit overlaps voice field");
  end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_CH    = 3,
  parameter int unsigned EN_LSB  = 8,
  parameter int unsigned SUM_BIT = 31,
  parameter int unsigned VC_LSB  = 5,
  parameter int unsigned VC_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CH-1:0]     done_pulse,
  input  logic                sctl_wr,
  input  logic [DATA_W-1:0]   sctl_wdata,
  input  logic [DATA_W/8-1:0] sctl_wstrb,
  output logic [DATA_W-1:0]   stat_word,
  output logic                irq
);

  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] en_fall;
  logic [N_CH-1:0] pend_q;

  irq_en_shadow #(.DATA_W(DATA_W), .N_CH(N_CH), .EN_LSB(EN_LSB)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (sctl_wr),
    .wdata   (sctl_wdata),
    .wstrb   (sctl_wstrb),
    .en_q    (en_q),
    .en_fall (en_fall)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    irq_pend_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (done_pulse[i]),
      .en    (en_q[i]),
      .clr   (en_fall[i]),
      .pend  (pend_q[i])
    );

    // R3/R5: a pending flag always has its enable on
    p_pend_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] |-> en_q[i]);
  end

  irq_status_pack #(
    .DATA_W  (DATA_W),
    .N_CH    (N_CH),
    .SUM_BIT (SUM_BIT),
    .VC_LSB  (VC_LSB),
    .VC_W    (VC_W),
    .VC_VAL  ({VC_W{1'b1}})
  ) u_pack (
    .pend (pend_q),
    .word (stat_word),
    .any  (irq)
  );

  // R8: the line only rises after a completion pulse
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|done_pulse));

  // R5: the line only falls after a disabling write
  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|en_fall));

endmodule

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  done_pulse = '0;
  logic        sctl_wr = 1'b0;
  logic [31:0] sctl_wdata = '0;
  logic [3:0]  sctl_wstrb = '0;
  logic [31:0] stat_word;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_status_agg uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_pulse (done_pulse),
    .sctl_wr    (sctl_wr),
    .sctl_wdata (sctl_wdata),
    .sctl_wstrb (sctl_wstrb),
    .stat_word  (stat_word),
    .irq        (irq)
  );

  // {we, wdata, wstrb, done, expected status after the edge}
  // Enable data: bit 8 DAC1, bit 9 DAC2, bit 10 ADC (R2).
  localparam int NV = 16;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {1'b0, 32'h0000_0000, 4'b0000, 3'b111, 32'h0000_0060}, // R3 no enables
    {1'b1, 32'h0000_0700, 4'b0010, 3'b000, 32'h0000_0060}, // enable all
    {1'b0, 32'h0000_0000, 4'b0000, 3'b001, 32'h8000_0061}, // R2 ADC -> bit0
    {1'b0, 32'h0000_0000, 4'b0000, 3'b100, 32'h8000_0065}, // R2 DAC1 -> bit2
    {1'b1, 32'h0000_0000, 4'b0001, 3'b000, 32'h8000_0065}, // R9 lane 0 only
    {1'b1, 32'h0000_0300, 4'b0010, 3'b000, 32'h8000_0064}, // R5 ADC off
    {1'b0, 32'h0000_0000, 4'b0000, 3'b011, 32'h8000_0066}, // R3 ADC ignored
    {1'b1, 32'h0000_0300, 4'b0010, 3'b100, 32'h8000_0066}, // R4/R7 rewrite
    {1'b1, 32'h0000_0000, 4'b0010, 3'b111, 32'h0000_0060}, // R6 clear wins
    {1'b1, 32'h0000_0200, 4'b0010, 3'b000, 32'h0000_0060}, // DAC2 only
    {1'b0, 32'h0000_0000, 4'b0000, 3'b010, 32'h8000_0062}, // R2 DAC2 -> bit1
    {1'b1, 32'h0000_0600, 4'b0010, 3'b000, 32'h8000_0062}, // R7 add ADC
    {1'b1, 32'h0000_0000, 4'b0000, 3'b000, 32'h8000_0062}, // R9 no strobes
    {1'b0, 32'h0000_0000, 4'b0000, 3'b001, 32'h8000_0063}, // ADC set
    {1'b1, 32'h0000_0000, 4'b1101, 3'b000, 32'h8000_0063}, // R9 other lanes
    {1'b1, 32'h0000_0000, 4'b0010, 3'b000, 32'h0000_0060}  // R5 both off
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [31:0] wd,
                       input logic [3:0] st, input logic [2:0] dn);
    sctl_wr = we; sctl_wdata = wd; sctl_wstrb = st; done_pulse = dn;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    // R1: state during and after reset
    #1;
    chk("R1 status in reset", stat_word, 32'h0000_0060);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 status after reset", stat_word, 32'h0000_0060);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    prev = stat_word;

    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      e = VEC[v];
      @(negedge clk);
      drive(e[71], e[70:39], e[38:35], e[34:32]);
      #1;
      chk("R3 no change before edge", stat_word, prev);
      @(posedge clk); #1;
      chk($sformatf("vector %0d status", v), stat_word, e[31:0]);
      chk($sformatf("R8 vector %0d irq", v), {31'b0, irq}, {31'b0, e[31]});
      prev = e[31:0];
    end
    @(negedge clk);
    drive(1'b0, '0, '0, '0);

    // R4: repeated pulses on a set flag change nothing
    @(negedge clk);
    drive(1'b1, 32'h0000_0700, 4'b0010, 3'b000);
    @(negedge clk);
    drive(1'b0, '0, '0, 3'b111);
    @(negedge clk);
    drive(1'b0, '0, '0, 3'b111);
    @(posedge clk); #1;
    chk("R4 all set stays", stat_word, 32'h8000_0067);

    // R1: reset mid-run clears flags and enables
    @(negedge clk);
    drive(1'b0, '0, '0, '0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset status", stat_word, 32'h0000_0060);
    chk("R1 async reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, '0, '0, 3'b111);
    @(posedge clk); #1;
    chk("R1 enables cleared by reset", stat_word, 32'h0000_0060);
    @(negedge clk);
    drive(1'b0, '0, '0, '0);

    // R7: writing 0 to already-clear enables leaves a set flag
    @(negedge clk);
    drive(1'b1, 32'h0000_0100, 4'b0010, 3'b000);
    @(negedge clk);
    drive(1'b0, '0, '0, 3'b100);
    @(negedge clk);
    drive(1'b1, 32'h0000_0100, 4'b0010, 3'b000);
    @(posedge clk); #1;
    chk("R7 ADC/DAC2 zero rewrite", stat_word, 32'h8000_0064);
    @(negedge clk);
    drive(1'b0, '0, '0, '0);
    @(posedge clk); #1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule